// File: doc/BRIEF.md
# Serial EEPROM Programming and Protection Controller

This block owns every path by which a serial EEPROM's contents can change. A separate serial front end decodes the command frames. It hands this controller one-cycle strobes for the set-enable, clear-enable, status-write and array-write commands. It also passes the start address, each received data byte, and a notice when chip select is released. That notice says whether the release landed exactly after the last bit of a whole byte. The controller keeps the write-enable latch and the two protection-level bits. From these it forms the status byte the front end shifts out.

An array write first gathers up to one page of bytes into a small buffer. The slot pointer steps through the page and wraps within it. When the frame closes on a byte boundary, the controller checks the page against the protected region and the external permit pin. If the page may be written, the controller starts a self-timed cycle. That cycle first copies the buffered bytes into the memory array, one per clock, through a registered write port. It then holds busy for a programmable number of clocks. A status write updates the protection level through the same timed cycle. Every cycle ends by dropping the write-enable latch.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: After a synchronous reset, `status_byte` is 0x00, `busy` is low, and `arr_we` stays low.
- R2: `op_set_wen` sets the write-enable latch (status bit 1) only while `wr_permit` is high. `op_clr_wen` clears the latch whatever `wr_permit` is.
- R3: Outside a cycle, `status_byte` reads {0000, level[1:0], wen, 0}, with the protection level in bits 3:2. While a cycle runs, it reads 0xFF.
- R4: An array write or status write issued while the latch is clear or `wr_permit` is low starts no cycle and writes nothing. The block is idle again once chip select is released.
- R5: The start address splits into a page number (upper ADDR_W-3 bits) and a slot (low 3 bits). Each data byte goes to the current slot, and the slot then steps by one, wrapping from 7 to 0 inside the same page. Array writes happen only while `busy` is high.
- R6: When more than 8 bytes arrive in one frame, each later byte replaces the byte already held in the slot it lands on.
- R7: A cycle starts only when `sel_release` comes with `sel_aligned` high and at least one data byte has been received. Any other release throws the frame away.
- R8: `wr_permit` going low while a frame is still being received cancels it. Once a cycle has started, `wr_permit` has no effect on it.
- R9: Protection levels: 00 protects nothing, 01 the top quarter of the array, 10 the top half, 11 all of it. A write to a protected page starts no cycle and writes nothing.
- R10: `busy` stays high for exactly 8 + WRITE_CYCLES clocks. Write enable is clear when it falls. Commands received while it is high have no effect.
- R11: A status write copies bits 3:2 of its data byte into the protection level at the end of its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_permit | input | 1 | High allows programming; low blocks it |
| op_set_wen | input | 1 | Set-write-enable command strobe |
| op_clr_wen | input | 1 | Clear-write-enable command strobe |
| op_status_wr | input | 1 | Status-write command strobe |
| op_array_wr | input | 1 | Array-write command strobe, qualifies `op_addr` |
| op_addr | input | ADDR_W | Start address of an array write |
| rx_byte | input | 8 | Received data byte |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| sel_release | input | 1 | Chip select was released |
| sel_aligned | input | 1 | The release fell right after a whole byte |
| busy | output | 1 | Self-timed cycle in progress |
| status_byte | output | 8 | Status byte for the front end |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
A latch or level bit in the wrong state shows up in `status_byte` in the same cycle it goes wrong. It also shows up, one frame later, as a write that was wrongly accepted or refused: `busy` either rises or stays low on the clock after release. A fault in the slot pointer or the buffer appears only after the cycle's 8 commit clocks, as bytes at the wrong addresses in the array image built from the write port. A fault in the timer appears as a wrong count of `busy` clocks, or as the latch still set when `busy` falls.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_SREG,
    ST_COMMIT,
    ST_WAIT
  } prog_state_t;
endpackage

// File: rtl/eeprom_prot_range.sv
module eeprom_prot_range #(
  parameter int ADDR_W = 9
) (
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // quarter = top two address bits both set; half = top bit set
  always_comb begin
    unique case (level)
      2'b00:   hit = 1'b0;
      2'b01:   hit = &addr[ADDR_W-1:ADDR_W-2];
      2'b10:   hit = addr[ADDR_W-1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_BITS = 3,
  parameter int DW        = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 wr_en,
  input  logic [PAGE_BITS-1:0] wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [PAGE_BITS-1:0] rd_idx,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_valid,
  output logic                 any_valid
);
  localparam int SLOTS = 1 << PAGE_BITS;

  logic [DW-1:0]    slot_data [SLOTS];
  logic [SLOTS-1:0] slot_vld;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic          v_q;
    logic [DW-1:0] d_q;
    logic          hit;
    assign hit = wr_en && (wr_idx == PAGE_BITS'(g));

    always_ff @(posedge clk) begin
      if (rst || clear) v_q <= 1'b0;
      else if (hit)     v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) d_q <= wr_data;
    end

    assign slot_vld[g]  = v_q;
    assign slot_data[g] = d_q;
  end

  assign rd_data   = slot_data[rd_idx];
  assign rd_valid  = slot_vld[rd_idx];
  assign any_valid = |slot_vld;
endmodule

// File: rtl/eeprom_cycle_timer.sv
module eeprom_cycle_timer #(
  parameter int CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == CW'(CYCLES - 1));
endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
  import eeprom_prog_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int PAGE_BITS    = 3,
  parameter int WRITE_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_permit,
  input  logic              op_set_wen,
  input  logic              op_clr_wen,
  input  logic              op_status_wr,
  input  logic              op_array_wr,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  input  logic              sel_release,
  input  logic              sel_aligned,
  output logic              busy,
  output logic [7:0]        status_byte,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int HI_W = ADDR_W - PAGE_BITS;
  localparam logic [PAGE_BITS-1:0] LAST_SLOT = '1;

  prog_state_t          state_q;
  logic                 wen_q;
  logic [1:0]           bp_q;
  logic [1:0]           bp_new_q;
  logic                 sr_got_q;
  logic                 is_sr_q;
  logic [HI_W-1:0]      page_q;
  logic [PAGE_BITS-1:0] ptr_q;
  logic [PAGE_BITS-1:0] idx_q;
  logic                 we_q;
  logic [ADDR_W-1:0]    waddr_q;
  logic [7:0]           wdata_q;

  logic       start_page;
  logic       start_sreg;
  logic       buf_wr;
  logic [7:0] buf_rd;
  logic       buf_rd_vld;
  logic       buf_any;
  logic       page_prot;
  logic       tmr_done;

  assign start_page = (state_q == ST_IDLE) && op_array_wr && wr_permit && wen_q;
  assign start_sreg = (state_q == ST_IDLE) && !op_array_wr && op_status_wr
                      && wr_permit && wen_q;
  assign buf_wr     = (state_q == ST_PAGE) && rx_valid && wr_permit && !sel_release;

  eeprom_page_buf #(.PAGE_BITS(PAGE_BITS), .DW(8)) page_buf_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_page),
    .wr_en     (buf_wr),
    .wr_idx    (ptr_q),
    .wr_data   (rx_byte),
    .rd_idx    (idx_q),
    .rd_data   (buf_rd),
    .rd_valid  (buf_rd_vld),
    .any_valid (buf_any)
  );

  eeprom_prot_range #(.ADDR_W(ADDR_W)) prot_i (
    .level (bp_q),
    .addr  ({page_q, {PAGE_BITS{1'b0}}}),
    .hit   (page_prot)
  );

  eeprom_cycle_timer #(.CYCLES(WRITE_CYCLES)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_WAIT),
    .done (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      wen_q    <= 1'b0;
      bp_q     <= 2'b00;
      bp_new_q <= 2'b00;
      sr_got_q <= 1'b0;
      is_sr_q  <= 1'b0;
      page_q   <= '0;
      ptr_q    <= '0;
      idx_q    <= '0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_page) begin
            state_q <= ST_PAGE;
            page_q  <= op_addr[ADDR_W-1:PAGE_BITS];
            ptr_q   <= op_addr[PAGE_BITS-1:0];
          end else if (start_sreg) begin
            state_q  <= ST_SREG;
            sr_got_q <= 1'b0;
          end else if (op_set_wen && wr_permit) begin
            wen_q <= 1'b1;
          end
        end
        ST_PAGE: begin
          if (!wr_permit) begin
            state_q <= ST_IDLE;
          end else if (sel_release) begin
            if (sel_aligned && buf_any && !page_prot) begin
              state_q <= ST_COMMIT;
              idx_q   <= '0;
              is_sr_q <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (rx_valid) begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        ST_SREG: begin
          if (!wr_permit) begin
            state_q <= ST_IDLE;
          end else if (sel_release) begin
            if (sel_aligned && sr_got_q) begin
              state_q <= ST_COMMIT;
              idx_q   <= '0;
              is_sr_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (rx_valid) begin
            bp_new_q <= rx_byte[3:2];
            sr_got_q <= 1'b1;
          end
        end
        ST_COMMIT: begin
          we_q    <= buf_rd_vld && !is_sr_q;
          waddr_q <= {page_q, idx_q};
          wdata_q <= buf_rd;
          idx_q   <= idx_q + 1'b1;
          if (idx_q == LAST_SLOT) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tmr_done) begin
            state_q <= ST_IDLE;
            wen_q   <= 1'b0;
            if (is_sr_q) bp_q <= bp_new_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (op_clr_wen && !busy) wen_q <= 1'b0;
    end
  end

  assign busy        = (state_q == ST_COMMIT) || (state_q == ST_WAIT);
  assign status_byte = busy ? 8'hFF : {4'b0000, bp_q, wen_q, 1'b0};
  assign arr_we      = we_q;
  assign arr_addr    = waddr_q;
  assign arr_wdata   = wdata_q;
endmodule

// File: rtl/eeprom_prog_ctrl_chk.sv
module eeprom_prog_ctrl_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_permit,
  input logic              op_set_wen,
  input logic              op_clr_wen,
  input logic              sel_release,
  input logic              busy,
  input logic [7:0]        status_byte,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [1:0]        level
);
  logic addr_locked;
  always_comb begin
    unique case (level)
      2'b00:   addr_locked = 1'b0;
      2'b01:   addr_locked = arr_addr[ADDR_W-1] && arr_addr[ADDR_W-2];
      2'b10:   addr_locked = arr_addr[ADDR_W-1];
      default: addr_locked = 1'b1;
    endcase
  end

  assert_we_in_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  assert_wen_needs_permit_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && op_set_wen && !wr_permit && !status_byte[1]) |=> !status_byte[1]);

  assert_wen_clear_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && op_clr_wen && !sel_release) |=> !status_byte[1]);

  assert_no_locked_write_R9: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !addr_locked);

  assert_wen_drops_at_end_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !status_byte[1]);
endmodule

bind eeprom_prog_ctrl eeprom_prog_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_permit   (wr_permit),
  .op_set_wen  (op_set_wen),
  .op_clr_wen  (op_clr_wen),
  .sel_release (sel_release),
  .busy        (busy),
  .status_byte (status_byte),
  .arr_we      (arr_we),
  .arr_addr    (arr_addr),
  .level       (bp_q)
);

// File: tb/eeprom_prog_ctrl_tb.sv
module eeprom_prog_ctrl_tb_top;
  localparam int AW    = 9;
  localparam int WC    = 50;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_permit, op_set_wen, op_clr_wen, op_status_wr, op_array_wr;
  logic [AW-1:0] op_addr;
  logic [7:0]    rx_byte;
  logic          rx_valid, sel_release, sel_aligned;
  logic          busy;
  logic [7:0]    status_byte;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;

  int n_checks = 0;
  int n_fail   = 0;
  int n_writes = 0;
  bit finished = 0;
  logic [7:0] mem_img [DEPTH];
  logic [7:0] exp_img [DEPTH];
  logic [1:0] exp_lvl = 2'b00;

  always #10 clk = ~clk;

  eeprom_prog_ctrl #(.ADDR_W(AW), .PAGE_BITS(3), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst(rst), .wr_permit(wr_permit), .op_set_wen(op_set_wen),
    .op_clr_wen(op_clr_wen), .op_status_wr(op_status_wr), .op_array_wr(op_array_wr),
    .op_addr(op_addr), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .sel_release(sel_release), .sel_aligned(sel_aligned), .busy(busy),
    .status_byte(status_byte), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  always @(posedge clk) begin
    if (arr_we) begin
      mem_img[arr_addr] <= arr_wdata;
      n_writes <= n_writes + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_image(string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem_img[i] !== exp_img[i]) bad++;
    check(req, bad, 0);
  endtask

  function automatic bit locked(logic [1:0] lv, logic [AW-1:0] a);
    case (lv)
      2'b00:   return 1'b0;
      2'b01:   return a >= 9'h180;
      2'b10:   return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic pulse(int which);
    @(negedge clk);
    op_set_wen = (which == 0);
    op_clr_wen = (which == 1);
    @(negedge clk);
    op_set_wen = 0; op_clr_wen = 0;
  endtask

  task automatic send_write(logic [AW-1:0] a, int n, logic [7:0] first,
                            bit aligned, bit expect_commit);
    @(negedge clk);
    op_array_wr = 1; op_addr = a;
    @(negedge clk);
    op_array_wr = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_byte = first + 8'(i);
      @(negedge clk);
    end
    rx_valid = 0;
    sel_release = 1; sel_aligned = aligned;
    @(negedge clk);
    sel_release = 0; sel_aligned = 0;
    if (expect_commit)
      for (int i = 0; i < n; i++)
        exp_img[{a[AW-1:3], 3'(a[2:0] + 3'(i))}] = first + 8'(i);
  endtask

  task automatic send_status(logic [7:0] v);
    @(negedge clk);
    op_status_wr = 1;
    @(negedge clk);
    op_status_wr = 0; rx_valid = 1; rx_byte = v;
    @(negedge clk);
    rx_valid = 0; sel_release = 1; sel_aligned = 1;
    @(negedge clk);
    sel_release = 0; sel_aligned = 0;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    while (busy && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1 status", status_byte, 8'h00);
    check("R1 busy", busy, 0);
    check("R1 no writes", n_writes, 0);
  endtask

  task automatic t_latch;
    wr_permit = 0; pulse(0);
    check("R2 set blocked by permit", status_byte[1], 0);
    wr_permit = 1; pulse(0);
    check("R2 set", status_byte, 8'h02);
    wr_permit = 0; pulse(1);
    check("R2 clear ignores permit", status_byte[1], 0);
    wr_permit = 1;
  endtask

  task automatic t_no_enable;
    int c;
    send_write(9'h040, 2, 8'h11, 1, 0);
    check("R4 no cycle without wen", busy, 0);
    pulse(0); wr_permit = 0;
    send_write(9'h040, 2, 8'h11, 1, 0);
    check("R4 no cycle permit low", busy, 0);
    wr_permit = 1;
    wait_idle(c);
    check_image("R4 image");
    pulse(1);
  endtask

  task automatic t_page;
    int c;
    pulse(0);
    send_write(9'h0A5, 3, 8'h31, 1, 1);
    check("R3 status during cycle", status_byte, 8'hFF);
    wr_permit = 0;
    wait_idle(c);
    wr_permit = 1;
    check("R10 busy length", c, 8 + WC);
    check("R10 wen cleared at end", status_byte, 8'h00);
    check_image("R5 R8 page written despite late permit drop");
  endtask

  task automatic t_wrap;
    int c;
    pulse(0);
    send_write(9'h0FE, 4, 8'h50, 1, 1);
    wait_idle(c);
    check_image("R5 slot wrap");
    pulse(0);
    send_write(9'h010, 10, 8'h70, 1, 1);
    wait_idle(c);
    check_image("R6 overrun replaces slots");
  endtask

  task automatic t_abort;
    int c;
    pulse(0);
    send_write(9'h020, 2, 8'h90, 0, 0);
    check("R7 unaligned release no cycle", busy, 0);
    send_write(9'h020, 0, 8'h00, 1, 0);
    check("R7 empty frame no cycle", busy, 0);
    @(negedge clk);
    op_array_wr = 1; op_addr = 9'h028;
    @(negedge clk);
    op_array_wr = 0; rx_valid = 1; rx_byte = 8'hA1;
    @(negedge clk);
    rx_valid = 0; wr_permit = 0;
    @(negedge clk);
    wr_permit = 1; rx_valid = 1; rx_byte = 8'hA2;
    @(negedge clk);
    rx_valid = 0; sel_release = 1; sel_aligned = 1;
    @(negedge clk);
    sel_release = 0; sel_aligned = 0;
    check("R8 permit drop cancels frame", busy, 0);
    wait_idle(c);
    check_image("R7 R8 image unchanged");
    pulse(1);
  endtask

  task automatic t_busy_ignore;
    int c;
    pulse(0);
    send_write(9'h030, 1, 8'hC3, 1, 1);
    pulse(0);
    send_write(9'h038, 1, 8'hC4, 1, 0);
    wait_idle(c);
    check("R10 length with commands during cycle", c < 2000, 1);
    @(negedge clk);
    check("R10 no second cycle", busy, 0);
    check_image("R10 ignored frame");
  endtask

  task automatic t_levels;
    int c;
    for (int lv = 1; lv < 4; lv++) begin
      pulse(0);
      send_status(8'(lv << 2));
      wait_idle(c);
      check("R11 level stored", status_byte, lv << 2);
      exp_lvl = 2'(lv);
      pulse(0);
      send_write(9'h1F8, 2, 8'hE0, 1, !locked(exp_lvl, 9'h1F8));
      check("R9 top page", busy, !locked(exp_lvl, 9'h1F8));
      wait_idle(c);
      pulse(0);
      send_write(9'h0F8, 2, 8'hE8, 1, !locked(exp_lvl, 9'h0F8));
      check("R9 lower half page", busy, !locked(exp_lvl, 9'h0F8));
      wait_idle(c);
      pulse(0);
      send_write(9'h170, 1, 8'hEC, 1, !locked(exp_lvl, 9'h170));
      check("R9 third quarter page", busy, !locked(exp_lvl, 9'h170));
      wait_idle(c);
      check_image("R9 image");
      pulse(1);
    end
    pulse(0);
    send_status(8'hF3);
    wait_idle(c);
    check("R11 level back to none, R3 upper bits zero", status_byte, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem_img[i] = 0; exp_img[i] = 0; end
    rst = 1; wr_permit = 1; op_set_wen = 0; op_clr_wen = 0; op_status_wr = 0;
    op_array_wr = 0; op_addr = 0; rx_byte = 0; rx_valid = 0;
    sel_release = 0; sel_aligned = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_no_enable();
    t_page();
    t_wrap();
    t_abort();
    t_busy_ignore();
    t_levels();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule